// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for a single read or write burst in a two-bank graphics DRAM. Each row has 256 columns. A start strobe samples the starting column, the burst length code and the ordering bit. From the next cycle on, the block outputs one column per cycle together with a valid flag. A last-beat flag marks the final column of a burst that has a fixed length.

Bursts of 1, 2, 4 or 8 columns stay inside an aligned block of that size. The start column's low bits give the starting position within the block. The beats then advance either by incrementing modulo the block size or by XOR of the start offset with a beat counter, and they never carry into the upper column bits. A full-page burst always runs in incrementing order over the whole row, wraps modulo 256, and continues until a terminate strobe stops it. A new start strobe always takes over from a running burst.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid_o` and `last_o` are low.
- R2: When `start_i` is high at a rising edge, the next cycle shows `valid_o` high and `col_o` equal to the sampled `start_col_i`.
- R3: Length codes on `len_code_i` give a burst of 1 beat for 0, 2 for 1, 4 for 2 and 8 for 3. Codes 4, 5 and 6 give a 1-beat burst. `valid_o` stays high for exactly that many consecutive cycles. `last_o` is high only on the final beat.
- R4: With `ilv_i`=0, beat k of a burst of length L is (start & ~(L-1)) + ((start + k) mod L).
- R5: With `ilv_i`=1, beat k of a burst of length L is (start & ~(L-1)) + ((start mod L) XOR k).
- R6: For every beat of a burst of length L, the column bits above log2(L) equal those of the start column. The address wraps inside the block.
- R7: Code 7 selects a full-page burst. Beat k is (start + k) mod 256, the burst runs until terminated, and `last_o` is never high during it.
- R8: A full-page burst uses incrementing order whatever `ilv_i` holds at the start strobe.
- R9: When `term_i` is high at an edge and `start_i` is low, the beat shown before that edge is the last one, and `valid_o` is low in the next cycle. A `term_i` pulse while no burst runs has no effect.
- R10: A `start_i` strobe during a running burst abandons that burst. The next cycle shows beat 0 of the new burst. `start_i` wins over `term_i` at the same edge.
- R11: `len_code_i`, `ilv_i` and `start_col_i` are sampled only on a start strobe. Changing them during a burst does not alter its columns or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| term_i | input | 1 | Stop the running burst after the current beat |
| len_code_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| ilv_i | input | 1 | Ordering: 0 incrementing, 1 interleaved |
| start_col_i | input | 8 | Starting column |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench sweeps every starting column against every fixed length in both orderings. A design that carried out of the aligned block, or that confused the two orderings, would give wrong columns at the wrap point or in the middle of a burst. While each burst runs, the bench drives opposite mode values, so a design that read the mode live instead of holding what it sampled would change its length or its columns. Separate runs cover a full-page burst longer than 256 beats with the interleaved bit set, terminates in the middle of a burst and while idle, the reserved length codes, and a restart during a burst. These runs catch a page counter that stops at 255, a page burst that takes the interleaved order, a stray last-beat flag, and a restart that arrives one cycle late.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
   localparam int LEN_CODE_W = 3;

   typedef enum logic [LEN_CODE_W-1:0] {
      BLEN_1    = 3'd0,
      BLEN_2    = 3'd1,
      BLEN_4    = 3'd2,
      BLEN_8    = 3'd3,
      BLEN_PAGE = 3'd7
   } blen_code_e;

   // log2 of the longest fixed-length burst
   localparam int MAX_FIXED_LOG = 3;
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [LEN_CODE_W-1:0] code_i,
   output logic [COL_W-1:0]      mask_o,
   output logic                  page_o
);
   logic short_ok;

   assign page_o   = (code_i == BLEN_PAGE);
   assign short_ok = !code_i[LEN_CODE_W-1];

   // One mask bit per column bit; low bits open up with the length code.
   for (genvar i = 0; i < COL_W; i++) begin : g_mask
      if (i < MAX_FIXED_LOG) begin : g_low
         assign mask_o[i] = page_o | (short_ok & (code_i > LEN_CODE_W'(i)));
      end else begin : g_high
         assign mask_o[i] = page_o;
      end
   end
endmodule

// File: rtl/burst_col_order.sv
module burst_col_order #(
   parameter int COL_W         = 8,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] fixed_hi;

   assign fixed_hi = base_i & ~mask_i;
   assign seq_low  = (base_i + cnt_i) & mask_i;

   if (INTERLEAVE_EN) begin : g_ilv
      logic [COL_W-1:0] ilv_low;
      assign ilv_low = (base_i ^ cnt_i) & mask_i;
      assign col_o   = fixed_hi | (ilv_i ? ilv_low : seq_low);
   end else begin : g_seq
      logic unused_ilv;
      assign unused_ilv = ilv_i;
      assign col_o      = fixed_hi | seq_low;
   end
endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  term_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  ilv_i,
   input  logic [COL_W-1:0]      start_col_i,
   output logic                  active_o,
   output logic [COL_W-1:0]      base_o,
   output logic [COL_W-1:0]      cnt_o,
   output logic [COL_W-1:0]      mask_o,
   output logic                  ilv_o,
   output logic                  page_o,
   output logic                  last_o
);
   logic [COL_W-1:0] new_mask;
   logic             new_page;
   logic             active_q, ilv_q, page_q;
   logic [COL_W-1:0] base_q, cnt_q, mask_q;

   burst_len_dec #(.COL_W(COL_W)) u_dec (
      .code_i (len_code_i),
      .mask_o (new_mask),
      .page_o (new_page)
   );

   assign last_o = active_q & ~page_q & (cnt_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ilv_q    <= 1'b0;
         page_q   <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
         mask_q   <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         ilv_q    <= ilv_i & ~new_page;
         page_q   <= new_page;
         base_q   <= start_col_i;
         cnt_q    <= '0;
         mask_q   <= new_mask;
      end else if (active_q) begin
         if (term_i || last_o) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + COL_W'(1);
         end
      end
   end

   assign active_o = active_q;
   assign base_o   = base_q;
   assign cnt_o    = cnt_q;
   assign mask_o   = mask_q;
   assign ilv_o    = ilv_q;
   assign page_o   = page_q;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int COL_W         = 8,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  term_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  ilv_i,
   input  logic [COL_W-1:0]      start_col_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o
);
   if (COL_W < MAX_FIXED_LOG) begin : g_bad_width
      $error("burst_col_gen: COL_W must cover the longest fixed burst");
   end

   logic             active;
   logic [COL_W-1:0] base, cnt, mask;
   logic             ilv_q, page;

   burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .term_i      (term_i),
      .len_code_i  (len_code_i),
      .ilv_i       (ilv_i),
      .start_col_i (start_col_i),
      .active_o    (active),
      .base_o      (base),
      .cnt_o       (cnt),
      .mask_o      (mask),
      .ilv_o       (ilv_q),
      .page_o      (page),
      .last_o      (last_o)
   );

   burst_col_order #(.COL_W(COL_W), .INTERLEAVE_EN(INTERLEAVE_EN)) u_order (
      .base_i (base),
      .cnt_i  (cnt),
      .mask_i (mask),
      .ilv_i  (ilv_q),
      .col_o  (col_o)
   );

   assign valid_o = active;

   // Marks cycles where $past refers to a post-reset cycle.
   logic hist_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) hist_ok <= 1'b0;
      else        hist_ok <= 1'b1;
   end

   AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o); // R3
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok && $past(last_o && !start_i) |-> !valid_o); // R3
   AST_START_COL: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok && $past(start_i) |-> valid_o && col_o == $past(start_col_i)); // R2
   AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok && $past(term_i && !start_i) |-> !valid_o); // R9
   AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && page) |-> !last_o); // R7
   AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok && valid_o && $past(valid_o) && !$past(start_i)
      |-> ((col_o ^ $past(col_o)) & ~mask) == '0); // R6
endmodule

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, term = 1'b0, typ = 1'b0;
   logic [2:0] code = '0;
   logic [7:0] scol = '0;
   logic [7:0] col;
   logic       valid, last;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   burst_col_gen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .term_i(term),
      .len_code_i(code), .ilv_i(typ), .start_col_i(scol),
      .col_o(col), .valid_o(valid), .last_o(last)
   );

   function automatic int blen(int c);
      if (c <= 3)  return 1 << c;
      if (c == 7)  return 256;
      return 1;
   endfunction

   function automatic int exp_col(int c, int t, int s, int k);
      int len, off, blk;
      len = blen(c);
      off = s % len;
      blk = s - off;
      if (t != 0 && c != 7) return blk + (off ^ k);
      return blk + ((off + k) % len);
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic check_beat(string req, int ecol, bit elast);
      check(valid === 1'b1, {req, " valid"}, int'(valid), 1);
      check(col === 8'(ecol), {req, " col"}, int'(col), ecol);
      check(last === elast, {req, " last"}, int'(last), int'(elast));
   endtask

   task automatic pulse_start(int c, int t, int s);
      start = 1'b1; code = 3'(c); typ = t[0]; scol = 8'(s);
      @(negedge clk);
      start = 1'b0;
      // R11: opposite mode values while the burst runs
      code = ~3'(c); typ = ~t[0]; scol = ~8'(s);
   endtask

   task automatic do_burst(int c, int t, int s, string req);
      int len;
      len = blen(c);
      @(negedge clk);
      pulse_start(c, t, s);
      for (int k = 0; k < len; k++) begin
         check_beat(req, exp_col(c, t, s, k), k == len - 1);
         @(negedge clk);
      end
      check(valid === 1'b0, {req, " end R3"}, int'(valid), 0);
   endtask

   initial begin
      #(8 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(valid === 1'b0 && last === 1'b0, "R1 in reset", int'(valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid === 1'b0 && last === 1'b0, "R1 after reset", int'(valid), 0);

      // R2 R3 R4 R5 R6 R11: every start column, fixed length and ordering
      for (int c = 0; c < 4; c++)
         for (int t = 0; t < 2; t++)
            for (int s = 0; s < 256; s++)
               do_burst(c, t, s, (t == 0) ? "R4 R6 seq" : "R5 R6 ilv");

      // R3: reserved codes give one beat
      for (int c = 4; c < 7; c++) begin
         do_burst(c, 0, 8'h5B, "R3 reserved");
         do_burst(c, 1, 8'hA6, "R3 reserved");
      end

      // R7 R8: full page, past the wrap, terminated
      for (int t = 0; t < 2; t++) begin
         @(negedge clk);
         pulse_start(7, t, 8'hF3);
         for (int k = 0; k < 300; k++) begin
            check_beat((t == 0) ? "R7 page" : "R8 page ilv", (8'hF3 + k) % 256, 1'b0);
            if (k == 299) term = 1'b1;
            @(negedge clk);
         end
         term = 1'b0;
         check(valid === 1'b0, "R9 page term", int'(valid), 0);
      end

      // R9: terminate a length-8 burst at beat 2
      @(negedge clk);
      pulse_start(3, 0, 8'h2D);
      check_beat("R9 pre", exp_col(3, 0, 8'h2D, 0), 1'b0);
      @(negedge clk);
      check_beat("R9 pre", exp_col(3, 0, 8'h2D, 1), 1'b0);
      @(negedge clk);
      check_beat("R9 pre", exp_col(3, 0, 8'h2D, 2), 1'b0);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      check(valid === 1'b0, "R9 mid term", int'(valid), 0);

      // R9: terminate while idle has no effect
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      check(valid === 1'b0 && last === 1'b0, "R9 idle term", int'(valid), 0);
      do_burst(2, 1, 8'h76, "R9 after idle term");

      // R10: restart during a burst, start beats term at the same edge
      @(negedge clk);
      pulse_start(3, 1, 8'h15);
      check_beat("R10 old", exp_col(3, 1, 8'h15, 0), 1'b0);
      @(negedge clk);
      check_beat("R10 old", exp_col(3, 1, 8'h15, 1), 1'b0);
      term = 1'b1;
      pulse_start(2, 0, 8'h43);
      term = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check_beat("R10 new", exp_col(2, 0, 8'h43, k), k == 3);
         @(negedge clk);
      end
      check(valid === 1'b0, "R10 end", int'(valid), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule